// File: doc/BRIEF.md
# Staged-Interrupt Receive Byte Buffer

This block sits between a byte-wide input port and a processor. Incoming bytes arrive on a valid strobe and are held in an eight-entry first-in first-out store. The processor pops them one at a time through a register read. A single-byte holding register must be serviced within one byte time. Here the processor can defer service for up to eight byte times, because the buffer reports its filling in stages.

Three interrupt sources are raised. The first marks each accepted byte. The second marks the occupancy reaching four. The third marks the store becoming full. Each source latches a sticky pending bit. A fourth sticky bit records bytes lost to a full store. Software masks each source with its own enable and clears pending bits by writing ones to them.

Top module: `rx_stage_buf`

## Requirements
- R1: Bytes are returned in arrival order, and up to DEPTH (8) bytes are held. `rd_data` shows the oldest held byte without removing it. A pop on `rd_pop` removes it at the clock edge. `level` gives the number of held bytes, from 0 to 8.
- R2: Every accepted write sets pending bit 0 (byte-received) on the following clock edge.
- R3: When an edge moves `level` from 3 to 4, pending bit 1 (mid-mark) is set.
- R4: When an edge moves `level` from 7 to 8, pending bit 2 (full) is set.
- R5: A write presented while `level` is 8 is discarded, even if a pop happens in the same cycle. It sets pending bit 3 (overrun), and the stored contents are not altered.
- R6: While the store is empty, `rd_data` reads 0. A pop while empty leaves `level` at 0 and sets no pending bit.
- R7: A write and a pop in the same cycle, with `level` between 1 and 7, leave `level` unchanged. Such a cycle sets only pending bit 0.
- R8: Pending bits are sticky. A cycle with `clr_we` high clears each pending bit whose `clr_mask` bit is 1. If a new event occurs in the same cycle, the event wins and its bit stays set.
- R9: `irq` is high exactly when a pending bit among 0 to 2 is set and its matching `irq_en` bit is 1. Overrun (bit 3) does not drive `irq`.
- R10: A synchronous active-high `rst` empties the store, clears every pending bit and drives `irq` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte strobe |
| in_data | input | DATA_W (8) | Input byte |
| rd_pop | input | 1 | Remove the oldest byte |
| rd_data | output | DATA_W (8) | Oldest byte, or 0 when empty |
| level | output | $clog2(DEPTH+1) (4) | Number of held bytes |
| irq_en | input | 3 | Enables for byte, mid-mark and full sources |
| clr_we | input | 1 | Write strobe of the clear register |
| clr_mask | input | 4 | Pending bits to clear (1 clears) |
| pending | output | 4 | Sticky flags: {overrun, full, mid-mark, byte} |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets these corner cases and the fault each would expose:
- A write during a full cycle that also pops: a design that let it in would corrupt order or miss the overrun flag.
- A balanced write and pop at occupancy three: a design that fired mid-mark here would interrupt spuriously.
- A clear arriving in the same cycle as a new byte: a design that gave the clear priority would lose that event.
- A pop from an empty store: a design that wrapped its counter here would report a level of fifteen.
- Masking through the enables: this catches an interrupt driven by a disabled source or by overrun.

// File: rtl/rx_stage_buf_pkg.sv
package rx_stage_buf_pkg;

    localparam int NUM_SRC  = 3;
    localparam int PEND_W   = 4;

    typedef enum logic [1:0] {
        SRC_BYTE = 2'd0,
        SRC_MID  = 2'd1,
        SRC_FULL = 2'd2,
        SRC_OVR  = 2'd3
    } src_idx_e;

    typedef struct packed {
        logic ovr;
        logic full;
        logic mid;
        logic byte_in;
    } rxb_events_t;

    function automatic logic [PEND_W-1:0] events_to_vec(input rxb_events_t ev);
        logic [PEND_W-1:0] v;
        v = '0;
        v[SRC_BYTE] = ev.byte_in;
        v[SRC_MID]  = ev.mid;
        v[SRC_FULL] = ev.full;
        v[SRC_OVR]  = ev.ovr;
        return v;
    endfunction

endpackage

// File: rtl/rxb_store.sv
module rxb_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_req,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_req,
    output logic [DATA_W-1:0] head,
    output logic [LVL_W-1:0]  level_q,
    output logic              accept,
    output logic              pop,
    output logic              drop
);

    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);
    localparam logic [AW-1:0]    LAST_IDX = AW'(DEPTH - 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr;
    logic [AW-1:0]     rd_ptr;
    logic              is_full;
    logic              is_empty;

    assign is_full  = (level_q == FULL_LVL);
    assign is_empty = (level_q == '0);
    assign accept   = wr_req && !is_full;
    assign drop     = wr_req && is_full;
    assign pop      = rd_req && !is_empty;
    assign head     = is_empty ? '0 : mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (accept) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            level_q <= '0;
        end else begin
            if (accept) begin
                wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + AW'(1);
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + AW'(1);
            end
            case ({accept, pop})
                2'b10:   level_q <= level_q + LVL_W'(1);
                2'b01:   level_q <= level_q - LVL_W'(1);
                default: level_q <= level_q;
            endcase
        end
    end

    assert_full_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (is_full && wr_req && !rd_req) |=> (level_q == FULL_LVL));

    assert_empty_pop_R6: assert property (@(posedge clk) disable iff (rst)
        (is_empty && rd_req && !wr_req) |=> (level_q == '0));

    assert_balanced_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_req && rd_req && !is_empty && !is_full) |=> $stable(level_q));

    assert_no_overflow_R1: assert property (@(posedge clk) disable iff (rst)
        level_q <= FULL_LVL);

endmodule

// File: rtl/rxb_events.sv
module rxb_events
    import rx_stage_buf_pkg::*;
#(
    parameter int DEPTH    = 8,
    parameter int MID_MARK = 4,
    localparam int LVL_W   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LVL_W-1:0] level_q,
    input  logic             accept,
    input  logic             pop,
    input  logic             drop,
    output rxb_events_t      ev
);

    localparam logic [LVL_W-1:0] MID_PREV  = LVL_W'(MID_MARK - 1);
    localparam logic [LVL_W-1:0] FULL_PREV = LVL_W'(DEPTH - 1);

    logic rising;

    assign rising = accept && !pop;

    always_comb begin
        ev         = '0;
        ev.byte_in = accept;
        ev.mid     = rising && (level_q == MID_PREV);
        ev.full    = rising && (level_q == FULL_PREV);
        ev.ovr     = drop;
    end

    assert_mid_needs_write_R3: assert property (@(posedge clk) disable iff (rst)
        ev.mid |-> ev.byte_in);

    assert_full_needs_write_R4: assert property (@(posedge clk) disable iff (rst)
        ev.full |-> ev.byte_in);

endmodule

// File: rtl/rxb_pending.sv
module rxb_pending
    import rx_stage_buf_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  rxb_events_t         ev,
    input  logic                clr_we,
    input  logic [PEND_W-1:0]   clr_mask,
    input  logic [NUM_SRC-1:0]  irq_en,
    output logic [PEND_W-1:0]   pend_q,
    output logic                irq
);

    logic [PEND_W-1:0] set_vec;
    logic [PEND_W-1:0] clr_vec;
    logic [PEND_W-1:0] keep_vec;

    assign set_vec  = events_to_vec(ev);
    assign clr_vec  = clr_we ? clr_mask : '0;
    assign keep_vec = pend_q & ~clr_vec;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else begin
            pend_q <= keep_vec | set_vec;
        end
    end

    assign irq = |(pend_q[NUM_SRC-1:0] & irq_en);

    assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend_q & $past(keep_vec)) == $past(keep_vec)));

    assert_event_wins_R8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend_q & $past(set_vec)) == $past(set_vec)));

    assert_overrun_sets_R5: assert property (@(posedge clk) disable iff (rst)
        ev.ovr |=> pend_q[SRC_OVR]);

endmodule

// File: rtl/rx_stage_buf.sv
module rx_stage_buf
    import rx_stage_buf_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int DEPTH    = 8,
    parameter int MID_MARK = 4,
    localparam int LVL_W   = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [DATA_W-1:0]   in_data,
    input  logic                rd_pop,
    output logic [DATA_W-1:0]   rd_data,
    output logic [LVL_W-1:0]    level,
    input  logic [NUM_SRC-1:0]  irq_en,
    input  logic                clr_we,
    input  logic [PEND_W-1:0]   clr_mask,
    output logic [PEND_W-1:0]   pending,
    output logic                irq
);

    logic        accept;
    logic        pop;
    logic        drop;
    rxb_events_t ev;

    rxb_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_req  (in_valid),
        .wr_data (in_data),
        .rd_req  (rd_pop),
        .head    (rd_data),
        .level_q (level),
        .accept  (accept),
        .pop     (pop),
        .drop    (drop)
    );

    rxb_events #(.DEPTH(DEPTH), .MID_MARK(MID_MARK)) u_events (
        .clk     (clk),
        .rst     (rst),
        .level_q (level),
        .accept  (accept),
        .pop     (pop),
        .drop    (drop),
        .ev      (ev)
    );

    rxb_pending u_pending (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .clr_we   (clr_we),
        .clr_mask (clr_mask),
        .irq_en   (irq_en),
        .pend_q   (pending),
        .irq      (irq)
    );

    assert_mid_level_R3: assert property (@(posedge clk) disable iff (rst)
        ev.mid |=> (level == LVL_W'(MID_MARK)));

    assert_full_level_R4: assert property (@(posedge clk) disable iff (rst)
        ev.full |=> (level == LVL_W'(DEPTH)));

    assert_byte_sets_R2: assert property (@(posedge clk) disable iff (rst)
        accept |=> pending[SRC_BYTE]);

    assert_reset_clears_R10: assert property (@(posedge clk)
        rst |=> (level == '0 && pending == '0));

endmodule

// File: tb/tb_rx_stage_buf.sv
module tb_rx_stage_buf;

    logic       clk = 1'b0;
    logic       rst;
    logic       in_valid;
    logic [7:0] in_data;
    logic       rd_pop;
    logic [7:0] rd_data;
    logic [3:0] level;
    logic [2:0] irq_en;
    logic       clr_we;
    logic [3:0] clr_mask;
    logic [3:0] pending;
    logic       irq;

    int checks   = 0;
    int failures = 0;

    always #10 clk = ~clk;

    rx_stage_buf dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .rd_pop(rd_pop), .rd_data(rd_data), .level(level), .irq_en(irq_en),
        .clr_we(clr_we), .clr_mask(clr_mask), .pending(pending), .irq(irq)
    );

    // {wr, data, rd, clr_we, clr_mask, exp_level, exp_pending, exp_head}
    localparam int NV = 14;
    localparam logic [30:0] VEC [NV] = '{
        {1'b1, 8'hA0, 1'b0, 1'b0, 4'b0000, 4'd1, 4'b0001, 8'h00},
        {1'b0, 8'h00, 1'b0, 1'b1, 4'b0001, 4'd1, 4'b0000, 8'hA0},
        {1'b1, 8'hA1, 1'b0, 1'b0, 4'b0000, 4'd2, 4'b0001, 8'hA0},
        {1'b1, 8'hA2, 1'b0, 1'b0, 4'b0000, 4'd3, 4'b0001, 8'hA0},
        {1'b1, 8'hA3, 1'b0, 1'b0, 4'b0000, 4'd4, 4'b0011, 8'hA0},
        {1'b1, 8'hA4, 1'b0, 1'b1, 4'b1111, 4'd5, 4'b0001, 8'hA0},
        {1'b1, 8'hA5, 1'b1, 1'b0, 4'b0000, 4'd5, 4'b0001, 8'hA0},
        {1'b1, 8'hA6, 1'b0, 1'b0, 4'b0000, 4'd6, 4'b0001, 8'hA1},
        {1'b1, 8'hA7, 1'b0, 1'b0, 4'b0000, 4'd7, 4'b0001, 8'hA1},
        {1'b1, 8'hA8, 1'b0, 1'b0, 4'b0000, 4'd8, 4'b0101, 8'hA1},
        {1'b1, 8'hA9, 1'b0, 1'b0, 4'b0000, 4'd8, 4'b1101, 8'hA1},
        {1'b1, 8'hAA, 1'b1, 1'b0, 4'b0000, 4'd7, 4'b1101, 8'hA1},
        {1'b0, 8'h00, 1'b0, 1'b1, 4'b1111, 4'd7, 4'b0000, 8'hA2},
        {1'b0, 8'h00, 1'b1, 1'b0, 4'b0000, 4'd6, 4'b0000, 8'hA2}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive at falling edge, sample head before the rising edge
    task automatic drive(input logic w, input logic [7:0] d, input logic r,
                         input logic cw, input logic [3:0] cm);
        @(negedge clk);
        in_valid = w; in_data = d; rd_pop = r; clr_we = cw; clr_mask = cm;
        #2;
    endtask

    task automatic settle();
        @(posedge clk);
        #2;
        in_valid = 1'b0; rd_pop = 1'b0; clr_we = 1'b0; clr_mask = 4'b0;
    endtask

    initial begin
        #(20 * 100000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_data = '0; rd_pop = 1'b0;
        irq_en = 3'b111; clr_we = 1'b0; clr_mask = '0;
        repeat (2) @(posedge clk);
        #2;
        chk("R10 reset level", 32'(level), 32'd0);
        chk("R10 reset pending", 32'(pending), 32'd0);
        chk("R10 reset irq", 32'(irq), 32'd0);
        @(negedge clk);
        rst = 1'b0;

        // vector table walk: R1 R2 R3 R4 R5 R7 R8 R9
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][30], VEC[i][29:22], VEC[i][21], VEC[i][20], VEC[i][19:16]);
            chk($sformatf("R1 head row %0d", i), 32'(rd_data), 32'(VEC[i][7:0]));
            settle();
            chk($sformatf("R1 level row %0d", i), 32'(level), 32'(VEC[i][15:12]));
            chk($sformatf("R8 pending row %0d", i), 32'(pending), 32'(VEC[i][11:8]));
            chk($sformatf("R9 irq row %0d", i), 32'(irq), 32'(|VEC[i][10:8]));
        end

        // R1 drain order A3..A8, R5 no dropped byte stored
        for (int k = 0; k < 6; k++) begin
            drive(1'b0, 8'h00, 1'b1, 1'b0, 4'b0);
            chk("R1 drain order", 32'(rd_data), 32'(8'hA3 + k));
            settle();
        end
        chk("R1 drained level", 32'(level), 32'd0);

        // R6 empty read
        drive(1'b0, 8'h00, 1'b1, 1'b0, 4'b0);
        chk("R6 empty data", 32'(rd_data), 32'd0);
        settle();
        chk("R6 empty level", 32'(level), 32'd0);
        chk("R6 empty pending", 32'(pending), 32'd0);

        // R7 balanced at level 3
        for (int k = 0; k < 3; k++) begin
            drive(1'b1, 8'hB0 + 8'(k), 1'b0, 1'b0, 4'b0);
            settle();
        end
        drive(1'b0, 8'h00, 1'b0, 1'b1, 4'b1111);
        settle();
        drive(1'b1, 8'hB3, 1'b1, 1'b0, 4'b0);
        chk("R7 head before", 32'(rd_data), 32'hB0);
        settle();
        chk("R7 level held", 32'(level), 32'd3);
        chk("R7 only byte event", 32'(pending), 32'b0001);

        // R3 mid-mark from 3 to 4 again
        drive(1'b1, 8'hB4, 1'b0, 1'b1, 4'b1111);
        settle();
        chk("R3 level four", 32'(level), 32'd4);
        chk("R3 mid-mark set", 32'(pending), 32'b0011);

        // R9 enable masking
        irq_en = 3'b100; #1;
        chk("R9 masked irq", 32'(irq), 32'd0);
        irq_en = 3'b010; #1;
        chk("R9 mid enabled irq", 32'(irq), 32'd1);
        drive(1'b0, 8'h00, 1'b0, 1'b1, 4'b0011);
        settle();
        chk("R9 cleared irq", 32'(irq), 32'd0);
        irq_en = 3'b111;

        // R10 reset mid-run
        @(negedge clk);
        in_valid = 1'b1; in_data = 8'hCC; rst = 1'b1;
        @(posedge clk); #2;
        chk("R10 rerun level", 32'(level), 32'd0);
        chk("R10 rerun pending", 32'(pending), 32'd0);
        chk("R10 rerun data", 32'(rd_data), 32'd0);
        @(negedge clk);
        rst = 1'b0; in_valid = 1'b0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule